// File: doc/BRIEF.md
# Semaphore-Gated Chained Command Sequencer

This block is a single DMA channel that walks a linked list of command words held in memory. Software places the address of the first command in the next-command pointer, clears the channel's stop bit, and releases work by writing a count into a hardware semaphore. While the semaphore is above zero and the stop bit is clear, the channel fetches the command at the pointer. It runs the command's data phase, which is modelled here as a fixed-latency stub, and then marks the command complete.

Each command word has three fields. The low ADDR_W bits hold a next-command address. Bit ADDR_W is the chain flag. Bit ADDR_W+1 is the decrement flag. A chained command moves the pointer to its next address. A command with the decrement flag takes one off the semaphore when it completes. Software can write to the semaphore while the channel runs, and the written value adds to the count, so commands appended to the list are released without a restart. Every completion raises a status bit, which drives the interrupt line when the interrupt enable is set. An unchained command parks the channel until the pointer is rewritten. An abort bit returns the channel to idle and empties the semaphore.

Top module: `cmdchain_dma`

## Requirements
- R1: The channel leaves idle and fetches only while the semaphore is nonzero; once the semaphore reaches zero, no further fetch is issued.
- R2: When a command completes, the semaphore drops by exactly one if bit ADDR_W+1 of that command word is 1, and is unchanged by the completion if that bit is 0.
- R3: The first fetch uses the pointer register (offset 8). After a command with bit ADDR_W set completes, the next fetch uses that command's bits [ADDR_W-1:0].
- R4: A nonzero write to the semaphore (offset 12, count in bits [7:0]) adds the count to the live value, including while commands are running.
- R5: Control bit 0 (stop) resets to 1. While it is 1 the channel issues no fetch and its data phase does not advance. Writing 1 to bit 0 at the clear alias (offset 2) lets the channel run.
- R6: Each completion sets status bit 0 (read at offset 4). The output irq equals status bit 0 ANDed with control bit 1.
- R7: A write to offset 1 (set alias) or offset 2 (clear alias) changes only the control bits written as 1. The same holds for offset 5 and offset 6 on status. Offset 0 writes the control bits directly, and offsets 0, 1 and 2 all read the control value.
- R8: Writing 1 to bit 2 at offset 1 aborts the channel. It stops fetching, the semaphore reads 0, and bit 2 of the control value always reads 0.
- R9: After a command with the chain bit clear completes, the channel parks and keeps its semaphore value. A write to the pointer register resumes it from the new address.
- R10: The semaphore is an 8-bit counter that saturates at 255, and a read returns its live value.
- R11: A write of zero to the semaphore has no effect. A semaphore write and a decrement in the same cycle give a single net update, so no count is lost.
- R12: After a chained run stops because the semaphore reached zero, the pointer register reads the next address from the last completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| fetch_req | output | 1 | Command fetch request |
| fetch_addr | output | ADDR_W | Address of the command being fetched |
| fetch_valid | input | 1 | Fetch data valid; accepted while fetch_req is high |
| fetch_data | input | ADDR_W+2 | Command word: {dec flag, chain flag, next address} |
| irq | output | 1 | Completion interrupt |

## Verification
A register write takes effect at the clock edge on which it is sampled, so the bench reads control, status, pointer and semaphore values on a later falling edge. A command becomes visible as a fetch handshake a few cycles after the semaphore goes nonzero: one cycle in idle, one in fetch, and one for the memory model's registered reply. Its completion, decrement and status update follow DATA_LAT+1 cycles later. The scoreboard therefore compares fetch addresses only at handshake cycles and in order, and register state is checked only after a settle wait longer than the worst-case command time. The concurrent-update case holds the semaphore write strobe high for twenty consecutive cycles, so that some write coincides with a completion cycle whatever the command period.

// File: rtl/cmdchain_pkg.sv
// Shared types and register map for the chained command sequencer.
// Assumes a 4-bit register offset space; offsets are fixed by this map.
package cmdchain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;
    localparam int SEM_W  = 8;

    localparam logic [REG_AW-1:0] OFS_CTRL     = 4'd0;
    localparam logic [REG_AW-1:0] OFS_CTRL_SET = 4'd1;
    localparam logic [REG_AW-1:0] OFS_CTRL_CLR = 4'd2;
    localparam logic [REG_AW-1:0] OFS_STAT     = 4'd4;
    localparam logic [REG_AW-1:0] OFS_STAT_SET = 4'd5;
    localparam logic [REG_AW-1:0] OFS_STAT_CLR = 4'd6;
    localparam logic [REG_AW-1:0] OFS_NEXT     = 4'd8;
    localparam logic [REG_AW-1:0] OFS_SEMA     = 4'd12;

    localparam int CTL_STOP  = 0;
    localparam int CTL_IRQEN = 1;
    localparam int CTL_ABORT = 2;
endpackage

// File: rtl/cmdchain_regs.sv
// Control and status registers with set/clear aliases.
// Decodes writes into strobes for the pointer, semaphore and abort.
// Assumes completion pulses last one cycle. A completion wins over a status clear in the same cycle.
module cmdchain_regs
    import cmdchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              cmd_done,
    output logic              stop,
    output logic              irq_en,
    output logic              stat_done,
    output logic              abort,
    output logic              ptr_wr,
    output logic              sema_wr
);
    logic wr_ctrl, wr_cset, wr_cclr, wr_sset, wr_sclr;
    logic unused_wdata;

    // Decode the write strobe per offset.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
        wr_cset = reg_wr && (reg_addr == OFS_CTRL_SET);
        wr_cclr = reg_wr && (reg_addr == OFS_CTRL_CLR);
        wr_sset = reg_wr && (reg_addr == OFS_STAT_SET);
        wr_sclr = reg_wr && (reg_addr == OFS_STAT_CLR);
        ptr_wr  = reg_wr && (reg_addr == OFS_NEXT);
        sema_wr = reg_wr && (reg_addr == OFS_SEMA) && (reg_wdata[SEM_W-1:0] != '0);
        abort   = wr_cset && reg_wdata[CTL_ABORT];
    end

    assign unused_wdata = ^reg_wdata;

    // Control bits: direct write, set alias, clear alias.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop   <= 1'b1;
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            stop   <= reg_wdata[CTL_STOP];
            irq_en <= reg_wdata[CTL_IRQEN];
        end else if (wr_cset) begin
            stop   <= stop   | reg_wdata[CTL_STOP];
            irq_en <= irq_en | reg_wdata[CTL_IRQEN];
        end else if (wr_cclr) begin
            stop   <= stop   & ~reg_wdata[CTL_STOP];
            irq_en <= irq_en & ~reg_wdata[CTL_IRQEN];
        end
    end

    // Completion status: set by hardware or alias, cleared by alias.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_done <= 1'b0;
        else
            stat_done <= cmd_done
                       | (wr_sset && reg_wdata[0])
                       | (stat_done && !(wr_sclr && reg_wdata[0]));
    end

    assert_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> stat_done);
endmodule

// File: rtl/cmdchain_sema.sv
// Saturating hardware semaphore.
// Combines a software increment and a completion decrement into one update per cycle.
// Assumes abort has priority over every other update.
module cmdchain_sema #(
    parameter int SEM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [SEM_W-1:0] inc_val,
    input  logic             dec_en,
    output logic [SEM_W-1:0] sem
);
    localparam logic [SEM_W:0] SEM_MAX = {1'b0, {SEM_W{1'b1}}};

    logic [SEM_W:0] up_sum;
    logic [SEM_W:0] net_sum;

    // Net next value: add the release, take one for the completion, then clamp.
    always_comb begin
        up_sum  = {1'b0, sem} + (inc_en ? {1'b0, inc_val} : '0);
        net_sum = up_sum - {{SEM_W{1'b0}}, (dec_en && (up_sum != '0))};
        if (net_sum > SEM_MAX)
            net_sum = SEM_MAX;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sem <= '0;
        else
            sem <= net_sum[SEM_W-1:0];
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc_en && !dec_en) |=> $stable(sem));
    assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc_en && !dec_en && sem == SEM_MAX[SEM_W-1:0]) |=> (sem == SEM_MAX[SEM_W-1:0]));
    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc_en && dec_en && sem != '0) |=> (sem == $past(sem) - 1'b1));
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sem == '0));
endmodule

// File: rtl/cmdchain_engine.sv
// Command walker: fetches a command word at the pointer, runs a fixed-latency data stub,
// then signals completion and follows the chain link.
// Assumes fetch_data is valid in the cycle that fetch_valid is high, and DATA_LAT >= 1.
module cmdchain_engine
    import cmdchain_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              abort,
    input  logic              sem_nonzero,
    input  logic              ptr_wr,
    input  logic [ADDR_W-1:0] ptr_wdata,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    input  logic [ADDR_W+1:0] fetch_data,
    output logic              cmd_done,
    output logic              dec_req,
    output logic [ADDR_W-1:0] next_ptr
);
    localparam int CNT_W     = $clog2(DATA_LAT + 1);
    localparam int CHAIN_BIT = ADDR_W;
    localparam int DEC_BIT   = ADDR_W + 1;

    seq_state_t        state;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W+1:0] cmd_q;
    logic [CNT_W-1:0]  cnt;
    logic              parked;

    // Sequencer state, pointer and data-phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            cmd_q  <= '0;
            cnt    <= '0;
            parked <= 1'b0;
        end else if (abort) begin
            state  <= ST_IDLE;
            parked <= 1'b0;
        end else begin
            if (ptr_wr) begin
                ptr    <= ptr_wdata;
                parked <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (run_en && sem_nonzero && !parked && !ptr_wr)
                        state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (run_en && fetch_valid) begin
                        cmd_q <= fetch_data;
                        cnt   <= CNT_W'(DATA_LAT - 1);
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (run_en) begin
                        if (cnt == '0)
                            state <= ST_DONE;
                        else
                            cnt <= cnt - 1'b1;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                    if (cmd_q[CHAIN_BIT])
                        ptr <= cmd_q[ADDR_W-1:0];
                    else
                        parked <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from state.
    always_comb begin
        fetch_req  = (state == ST_FETCH) && run_en;
        fetch_addr = ptr;
        cmd_done   = (state == ST_DONE);
        dec_req    = (state == ST_DONE) && cmd_q[DEC_BIT];
        next_ptr   = ptr;
    end

    assert_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sem_nonzero) |=> !fetch_req);
    assert_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && state != ST_DONE) |=> !cmd_done);
    assert_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && cmd_q[CHAIN_BIT] && !abort) |=> (fetch_addr == $past(cmd_q[ADDR_W-1:0])));
endmodule

// File: rtl/cmdchain_dma.sv
// Top of the chained command sequencer.
// Joins the register block, the semaphore and the command walker, and drives the read mux and irq.
// Assumes reads are combinational on reg_addr.
module cmdchain_dma
    import cmdchain_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    input  logic [ADDR_W+1:0] fetch_data,
    output logic              irq
);
    logic              stop, irq_en, stat_done, abort, ptr_wr, sema_wr;
    logic              cmd_done, dec_req;
    logic [SEM_W-1:0]  sem;
    logic [ADDR_W-1:0] next_ptr;

    cmdchain_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmd_done  (cmd_done),
        .stop      (stop),
        .irq_en    (irq_en),
        .stat_done (stat_done),
        .abort     (abort),
        .ptr_wr    (ptr_wr),
        .sema_wr   (sema_wr)
    );

    cmdchain_sema #(.SEM_W(SEM_W)) u_sema (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (abort),
        .inc_en  (sema_wr),
        .inc_val (reg_wdata[SEM_W-1:0]),
        .dec_en  (dec_req),
        .sem     (sem)
    );

    cmdchain_engine #(.ADDR_W(ADDR_W), .DATA_LAT(DATA_LAT)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (!stop),
        .abort       (abort),
        .sem_nonzero (sem != '0),
        .ptr_wr      (ptr_wr),
        .ptr_wdata   (reg_wdata[ADDR_W-1:0]),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .cmd_done    (cmd_done),
        .dec_req     (dec_req),
        .next_ptr    (next_ptr)
    );

    // Read mux over the register map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL, OFS_CTRL_SET, OFS_CTRL_CLR: begin
                reg_rdata[CTL_STOP]  = stop;
                reg_rdata[CTL_IRQEN] = irq_en;
            end
            OFS_STAT, OFS_STAT_SET, OFS_STAT_CLR: reg_rdata[0] = stat_done;
            OFS_NEXT: reg_rdata[ADDR_W-1:0] = next_ptr;
            OFS_SEMA: reg_rdata[SEM_W-1:0]  = sem;
            default:  reg_rdata = '0;
        endcase
    end

    // Interrupt: completion status gated by its enable.
    assign irq = stat_done && irq_en;

    assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && irq_en && !(reg_wr && reg_addr == OFS_CTRL_CLR)) |=> irq);
endmodule

// File: tb/tb_cmdchain_dma.sv
`timescale 1ns/1ps
module tb_cmdchain_dma;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_valid = 1'b0;
    logic [AW+1:0] fetch_data = '0;
    logic          irq;

    logic [AW+1:0] mem [0:63];
    int            vectors = 0;
    int            errors = 0;
    int            fetches = 0;
    bit            loose = 1'b0;
    bit            finished = 1'b0;
    int            exp_q[$];

    cmdchain_dma #(.ADDR_W(AW), .DATA_LAT(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .irq(irq)
    );

    always #2 clk = ~clk;

    // Memory model: registered one-cycle reply to a fetch request.
    always @(posedge clk) begin
        fetch_valid <= fetch_req && !fetch_valid;
        fetch_data  <= mem[fetch_addr[5:0]];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compares each fetch handshake against the expected queue.
    always @(negedge clk) begin
        if (rst_n && fetch_req && fetch_valid) begin
            fetches++;
            if (loose) begin
                check(fetch_addr == 20 || fetch_addr == 21, "R3 loop", int'(fetch_addr), 20);
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected fetch", int'(fetch_addr), -1);
            end else begin
                automatic int e = exp_q.pop_front();
                check(fetch_addr == e, "R3 fetch order", int'(fetch_addr), e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic expect_fetch(input int a);
        exp_q.push_back(a);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int v;
        int f0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        // Word = {dec, chain, next[15:0]}
        mem[1]  = {1'b1, 1'b1, 16'd2};
        mem[2]  = {1'b1, 1'b1, 16'd3};
        mem[3]  = {1'b1, 1'b1, 16'd4};
        mem[4]  = {1'b1, 1'b1, 16'd5};
        mem[5]  = {1'b0, 1'b1, 16'd6};
        mem[6]  = {1'b1, 1'b1, 16'd7};
        mem[7]  = {1'b1, 1'b0, 16'd9};
        mem[10] = {1'b1, 1'b1, 16'd11};
        mem[11] = {1'b0, 1'b0, 16'd12};
        mem[20] = {1'b0, 1'b1, 16'd21};
        mem[21] = {1'b0, 1'b1, 16'd20};
        for (int i = 30; i < 50; i++) mem[i] = {1'b1, 1'b1, 16'(i + 1)};

        settle(3);
        rst_n = 1'b1;
        settle(2);

        // Reset state
        rd(4'd0, v);  check(v == 1, "R5 reset ctrl", v, 1);
        rd(4'd4, v);  check(v == 0, "R6 reset status", v, 0);
        rd(4'd12, v); check(v == 0, "R10 reset sema", v, 0);
        check(irq == 1'b0, "R6 reset irq", int'(irq), 0);

        // R5: stopped channel does not fetch even with work released
        wr(4'd8, 32'd1);
        wr(4'd12, 32'd2);
        f0 = fetches;
        settle(20);
        check(fetches == f0, "R5 stopped no fetch", fetches - f0, 0);
        rd(4'd12, v); check(v == 2, "R10 live sema", v, 2);

        // R1, R5: release stop, two chained commands then halt at zero
        expect_fetch(1); expect_fetch(2);
        wr(4'd2, 32'd1);
        settle(60);
        drained("R1 two commands");
        rd(4'd12, v); check(v == 0, "R1 sema drained", v, 0);
        rd(4'd8, v);  check(v == 3, "R12 pointer after halt", v, 3);
        rd(4'd4, v);  check(v == 1, "R6 status set", v, 1);
        check(irq == 1'b0, "R6 irq masked", int'(irq), 0);

        // R6, R7: enable irq via set alias, clear status via clear alias
        wr(4'd1, 32'd2);
        rd(4'd0, v); check(v == 2, "R7 ctrl set alias", v, 2);
        check(irq == 1'b1, "R6 irq enabled", int'(irq), 1);
        wr(4'd6, 32'd1);
        rd(4'd4, v); check(v == 0, "R7 status clear alias", v, 0);
        check(irq == 1'b0, "R6 irq after clear", int'(irq), 0);

        // R4: append while running
        expect_fetch(3); expect_fetch(4);
        wr(4'd12, 32'd1);
        settle(3);
        wr(4'd12, 32'd1);
        settle(60);
        drained("R4 appended command");
        rd(4'd8, v); check(v == 5, "R4 pointer", v, 5);
        check(irq == 1'b1, "R6 irq on completion", int'(irq), 1);

        // R2: command without decrement flag keeps count
        expect_fetch(5); expect_fetch(6);
        wr(4'd12, 32'd1);
        settle(60);
        drained("R2 no-dec command");
        rd(4'd12, v); check(v == 0, "R2 sema", v, 0);
        rd(4'd8, v);  check(v == 7, "R2 pointer", v, 7);

        // R9: unchained command parks, count kept
        expect_fetch(7);
        wr(4'd12, 32'd3);
        settle(60);
        drained("R9 park");
        rd(4'd12, v); check(v == 2, "R9 sema kept", v, 2);
        expect_fetch(10); expect_fetch(11);
        wr(4'd8, 32'd10);
        settle(60);
        drained("R9 resume");
        rd(4'd12, v); check(v == 1, "R9 sema after resume", v, 1);

        // R8: abort a looping chain
        loose = 1'b1;
        wr(4'd8, 32'd20);
        settle(40);
        check(fetches > f0 + 10, "R8 loop running", fetches, f0 + 11);
        wr(4'd1, 32'd4);
        settle(3);
        loose = 1'b0;
        f0 = fetches;
        settle(30);
        check(fetches == f0, "R8 no fetch after abort", fetches - f0, 0);
        rd(4'd12, v); check(v == 0, "R8 sema cleared", v, 0);
        rd(4'd0, v);  check(v == 2, "R8 abort bit reads 0", v, 2);

        // R10, R11: saturation and zero write, while stopped
        wr(4'd1, 32'd1);
        wr(4'd12, 32'd200);
        wr(4'd12, 32'd100);
        rd(4'd12, v); check(v == 255, "R10 saturate", v, 255);
        wr(4'd12, 32'd0);
        rd(4'd12, v); check(v == 255, "R11 zero write", v, 255);
        wr(4'd1, 32'd4);
        rd(4'd12, v); check(v == 0, "R8 abort clears", v, 0);

        // R11: back-to-back releases overlapping completions
        wr(4'd8, 32'd30);
        for (int i = 30; i < 50; i++) expect_fetch(i);
        wr(4'd2, 32'd1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd12; reg_wdata = 32'd1;
        repeat (20) @(negedge clk);
        reg_wr = 1'b0;
        settle(300);
        drained("R11 net update");
        rd(4'd12, v); check(v == 0, "R11 sema net", v, 0);
        rd(4'd8, v);  check(v == 50, "R11 pointer", v, 50);

        finish_run();
    end
endmodule